// File: doc/BRIEF.md
# Encoder Edge Counter with Event Flags

This block counts pulses from an encoder-style input pair. Input A is the pulse line. A rising edge of A adds one to a signed count, and a falling edge of A subtracts one. Input B acts as a gate: counting happens only while B is low. A hold input and a run enable, which stands for the controlling ladder rung, can also freeze the count. A third line, Z, brings the count back to zero when it is high while both A and B are low. This reset applies even when the count is held or disabled.

The count wraps around at both ends of its signed range. The step from the largest positive value to the most negative value is reported as overflow, and the step in the other direction is reported as underflow. Each is a distinct event. A decrement that lands on the programmable low preset is a low-preset event, and an increment that lands on the high preset is a high-preset event. Overflow, underflow and low preset each set a sticky flag that the host clears with its own strobe. When interrupts are enabled, every event also loads a one-hot cause register and raises a one-cycle interrupt request.

A, B, Z and hold are asynchronous pins, so each passes through a synchroniser before use. The run enable, interrupt enable, presets and clear strobes are synchronous control inputs. There is no streaming data path, so every pin is a plain level or strobe and none uses valid/ready back-pressure.

Top module: `edge_count_unit`

## Requirements
- R1: On a rising edge of A, the count increases by one if B is low, run_en is high and hold is low.
- R2: On a falling edge of A, under the same conditions as R1, the count decreases by one.
- R3: While B is high, edges of A leave the count unchanged.
- R4: While run_en is low or hold is high, edges of A leave the count unchanged.
- R5: When A is low, B is low and Z is high, the count becomes zero regardless of hold and run_en. This zeroing takes priority over an A edge that is seen in the same cycle.
- R6: An increment from the largest positive value wraps to the most negative value and sets the sticky overflow flag.
- R7: A decrement from the most negative value wraps to the largest positive value and sets the sticky underflow flag.
- R8: A decrement whose result equals preset_lo sets the sticky low-preset flag. An increment that lands on preset_lo does not set it.
- R9: An increment whose result equals preset_hi is a high-preset event. It has no sticky flag and is reported only through the cause register and the interrupt request.
- R10: The cause register is one-hot: bit 0 is high preset, bit 1 is low preset, bit 2 is overflow and bit 3 is underflow.
  - With irq_en high, an event sets its own bit, clears the other three and pulses irq for exactly one cycle.
  - If two events coincide, overflow or underflow wins over the presets.
  - With irq_en low, cause keeps its value and irq stays low.
- R11: Each sticky flag clears only through its own strobe (clr_lp, clr_ov, clr_un). The other flags are not affected. If a set and a clear meet in the same cycle, the flag ends up set.
- R12: A change on A, B, Z or hold is reflected in count, flags, cause and irq on the third rising clock edge after it. run_en, irq_en, the presets and the clear strobes act on the next rising edge.
- R13: After reset, the count, all flags, cause and irq are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | 1 | Pulse input; edges count up (rising) or down (falling) |
| b_in | input | 1 | Gate input; high blocks counting |
| z_in | input | 1 | Zeroing input; acts when A and B are both low |
| hold_in | input | 1 | High freezes the count |
| run_en | input | 1 | Rung enable; low freezes the count |
| irq_en | input | 1 | Enables cause updates and interrupt requests |
| preset_lo | input | W | Signed low preset, compared after decrements |
| preset_hi | input | W | Signed high preset, compared after increments |
| clr_lp | input | 1 | Clear strobe for the low-preset flag |
| clr_ov | input | 1 | Clear strobe for the overflow flag |
| clr_un | input | 1 | Clear strobe for the underflow flag |
| count | output | W | Signed count value |
| flag_lp | output | 1 | Sticky low-preset flag |
| flag_ov | output | 1 | Sticky overflow flag |
| flag_un | output | 1 | Sticky underflow flag |
| cause | output | 4 | One-hot interrupt cause (bit0 HP, bit1 LP, bit2 OV, bit3 UN) |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Each pin change on A, B, Z or hold takes three rising edges to appear at the outputs. A clear strobe takes one edge. The driver stamps every expected item with the clock count at which the result is due. The monitor compares the item at the falling edge that follows that rising edge. The bench also compares at the next falling edge, where irq must already have dropped while the count and flags stay put. Clear strobes are timed to land on the same edge as the counting result, so the case where a set and a clear coincide is checked at its exact cycle.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

  // bit positions of the synchronised pin vector
  localparam int unsigned PIN_A    = 0;
  localparam int unsigned PIN_B    = 1;
  localparam int unsigned PIN_Z    = 2;
  localparam int unsigned PIN_HOLD = 3;
  localparam int unsigned PIN_CNT  = 4;

  // one-hot cause bit positions
  localparam int unsigned CAUSE_HP = 0;
  localparam int unsigned CAUSE_LP = 1;
  localparam int unsigned CAUSE_OV = 2;
  localparam int unsigned CAUSE_UN = 3;
  localparam int unsigned CAUSE_W  = 4;

  // one decoded count action per cycle
  typedef struct packed {
    logic zero;
    logic up;
    logic down;
  } step_t;

  // events produced by the accumulator in the cycle it updates
  typedef struct packed {
    logic hp;
    logic lp;
    logic ov;
    logic un;
  } evt_t;

endpackage

// File: rtl/ecu_sync.sv
module ecu_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [STAGES-1:0][N-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ecu_step_decode.sv
module ecu_step_decode
  import ecu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a_s,
  input  logic  b_s,
  input  logic  z_s,
  input  logic  hold_s,
  input  logic  run_en,
  output step_t step
);

  logic a_prev;
  logic a_edge;
  logic zero_cond;
  logic gate_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_prev <= 1'b0;
    else        a_prev <= a_s;
  end

  always_comb begin
    a_edge    = a_s ^ a_prev;
    zero_cond = !a_s && !b_s && z_s;
    gate_ok   = a_edge && !b_s && run_en && !hold_s && !zero_cond;
    step.zero = zero_cond;
    step.up   = gate_ok && a_s;
    step.down = gate_ok && !a_s;
  end

endmodule

// File: rtl/ecu_accum.sv
module ecu_accum
  import ecu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  step_t        step,
  input  logic [W-1:0] preset_lo,
  input  logic [W-1:0] preset_hi,
  output logic [W-1:0] count,
  output evt_t         evt
);

  localparam logic [W-1:0] TOP_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] TOP_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    evt   = '0;
    if (step.zero) begin
      cnt_d = '0;
    end else if (step.up) begin
      cnt_d  = cnt_q + ONE;
      evt.ov = (cnt_q == TOP_POS);
      evt.hp = (cnt_d == preset_hi);
    end else if (step.down) begin
      cnt_d  = cnt_q - ONE;
      evt.un = (cnt_q == TOP_NEG);
      evt.lp = (cnt_d == preset_lo);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/ecu_status.sv
module ecu_status
  import ecu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_en,
  input  evt_t               evt,
  input  logic               clr_lp,
  input  logic               clr_ov,
  input  logic               clr_un,
  output logic               flag_lp,
  output logic               flag_ov,
  output logic               flag_un,
  output logic [CAUSE_W-1:0] cause,
  output logic               irq
);

  localparam int NFLAG = 3;

  logic [NFLAG-1:0]   set_v;
  logic [NFLAG-1:0]   clr_v;
  logic [NFLAG-1:0]   flg_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [CAUSE_W-1:0] cause_d;
  logic               any_evt;
  logic               irq_q;

  assign set_v   = {evt.un, evt.ov, evt.lp};
  assign clr_v   = {clr_un, clr_ov, clr_lp};
  assign any_evt = evt.hp | evt.lp | evt.ov | evt.un;

  // sticky flags: a set in the same cycle beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else begin
      for (int i = 0; i < NFLAG; i++) begin
        flg_q[i] <= set_v[i] | (flg_q[i] & ~clr_v[i]);
      end
    end
  end

  // wraparound events outrank preset events
  always_comb begin
    cause_d = cause_q;
    if (irq_en && any_evt) begin
      cause_d = '0;
      if      (evt.ov) cause_d[CAUSE_OV] = 1'b1;
      else if (evt.un) cause_d[CAUSE_UN] = 1'b1;
      else if (evt.lp) cause_d[CAUSE_LP] = 1'b1;
      else             cause_d[CAUSE_HP] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      irq_q   <= irq_en && any_evt;
    end
  end

  assign flag_lp = flg_q[0];
  assign flag_ov = flg_q[1];
  assign flag_un = flg_q[2];
  assign cause   = cause_q;
  assign irq     = irq_q;

endmodule

// File: rtl/edge_count_unit.sv
module edge_count_unit
  import ecu_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_in,
  input  logic         b_in,
  input  logic         z_in,
  input  logic         hold_in,
  input  logic         run_en,
  input  logic         irq_en,
  input  logic [W-1:0] preset_lo,
  input  logic [W-1:0] preset_hi,
  input  logic         clr_lp,
  input  logic         clr_ov,
  input  logic         clr_un,
  output logic [W-1:0] count,
  output logic         flag_lp,
  output logic         flag_ov,
  output logic         flag_un,
  output logic [3:0]   cause,
  output logic         irq
);

  logic [PIN_CNT-1:0] pins_raw;
  logic [PIN_CNT-1:0] pins_s;
  logic               a_s;
  logic               b_s;
  logic               z_s;
  logic               hold_s;
  step_t              step;
  evt_t               evt;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_A]    = a_in;
    pins_raw[PIN_B]    = b_in;
    pins_raw[PIN_Z]    = z_in;
    pins_raw[PIN_HOLD] = hold_in;
  end

  ecu_sync #(.N(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign a_s    = pins_s[PIN_A];
  assign b_s    = pins_s[PIN_B];
  assign z_s    = pins_s[PIN_Z];
  assign hold_s = pins_s[PIN_HOLD];

  ecu_step_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_s    (a_s),
    .b_s    (b_s),
    .z_s    (z_s),
    .hold_s (hold_s),
    .run_en (run_en),
    .step   (step)
  );

  ecu_accum #(.W(W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .preset_lo (preset_lo),
    .preset_hi (preset_hi),
    .count     (count),
    .evt       (evt)
  );

  ecu_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_en  (irq_en),
    .evt     (evt),
    .clr_lp  (clr_lp),
    .clr_ov  (clr_ov),
    .clr_un  (clr_un),
    .flag_lp (flag_lp),
    .flag_ov (flag_ov),
    .flag_un (flag_un),
    .cause   (cause),
    .irq     (irq)
  );

endmodule

// File: rtl/ecu_checker.sv
module ecu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic         irq_en,
  input logic         clr_lp,
  input logic         clr_ov,
  input logic         clr_un,
  input logic         a_s,
  input logic         b_s,
  input logic         z_s,
  input logic         hold_s,
  input logic [W-1:0] count,
  input logic         flag_lp,
  input logic         flag_ov,
  input logic         flag_un,
  input logic [3:0]   cause,
  input logic         irq
);

  localparam logic [W-1:0] TOP_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] TOP_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic zc;
  assign zc = !a_s && !b_s && z_s;

  p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |->
      (count == W'($past(count) + ONE) || count == W'($past(count) - ONE) || count == '0));

  p_b_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(b_s) |-> (count == $past(count)));

  p_hold_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_s && !zc) |-> (count == $past(count)));

  p_run_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_en && !zc) |-> (count == $past(count)));

  p_zeroing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(zc) |-> (count == '0));

  p_ov_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == TOP_POS && count == TOP_NEG) |-> flag_ov);

  p_un_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == TOP_NEG && count == TOP_POS) |-> flag_un);

  p_cause_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause));

  p_irq_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($countones(cause) == 1 && $past(irq_en)));

  p_cause_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (cause == $past(cause)));

  p_lp_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag_lp && !clr_lp) |-> flag_lp);

  p_ov_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag_ov && !clr_ov) |-> flag_ov);

  p_un_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag_un && !clr_un) |-> flag_un);

endmodule

bind edge_count_unit ecu_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_en  (run_en),
  .irq_en  (irq_en),
  .clr_lp  (clr_lp),
  .clr_ov  (clr_ov),
  .clr_un  (clr_un),
  .a_s     (a_s),
  .b_s     (b_s),
  .z_s     (z_s),
  .hold_s  (hold_s),
  .count   (count),
  .flag_lp (flag_lp),
  .flag_ov (flag_ov),
  .flag_un (flag_un),
  .cause   (cause),
  .irq     (irq)
);

// File: tb/sim_edge_count_unit.sv
`timescale 1ns/1ps
module sim_edge_count_unit;

  localparam int W    = 6;
  localparam int VMAX = (1 << (W-1)) - 1;
  localparam int VMIN = -(1 << (W-1));

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         a_in = 1'b0, b_in = 1'b0, z_in = 1'b0, hold_in = 1'b0;
  logic         run_en = 1'b1, irq_en = 1'b1;
  logic [W-1:0] preset_lo = '0, preset_hi = '0;
  logic         clr_lp = 1'b0, clr_ov = 1'b0, clr_un = 1'b0;
  logic [W-1:0] count;
  logic         flag_lp, flag_ov, flag_un, irq;
  logic [3:0]   cause;

  always #4 clk = ~clk;

  edge_count_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .z_in(z_in),
    .hold_in(hold_in), .run_en(run_en), .irq_en(irq_en),
    .preset_lo(preset_lo), .preset_hi(preset_hi),
    .clr_lp(clr_lp), .clr_ov(clr_ov), .clr_un(clr_un),
    .count(count), .flag_lp(flag_lp), .flag_ov(flag_ov), .flag_un(flag_un),
    .cause(cause), .irq(irq)
  );

  typedef struct {
    int       due;
    int       cnt;
    bit       lp, ov, un;
    bit [3:0] cause;
    bit       irq;
    string    tag;
  } exp_t;

  exp_t  sb[$];
  exp_t  mon_e;
  int    cyc = 0;
  int    n_checks = 0;
  int    n_fail = 0;

  // reference model state
  int       m_cnt = 0;
  bit       m_a = 0;
  bit       m_lp = 0, m_ov = 0, m_un = 0;
  bit [3:0] m_cause = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each item at the cycle it falls due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      mon_e = sb.pop_front();
      n_checks++;
      if (mon_e.due != cyc || $signed(count) != mon_e.cnt || flag_lp != mon_e.lp ||
          flag_ov != mon_e.ov || flag_un != mon_e.un || cause != mon_e.cause ||
          irq != mon_e.irq) begin
        n_fail++;
        $display("FAIL %s: got cnt=%0d lp=%0b ov=%0b un=%0b cause=%b irq=%0b, expected cnt=%0d lp=%0b ov=%0b un=%0b cause=%b irq=%0b",
                 mon_e.tag, $signed(count), flag_lp, flag_ov, flag_un, cause, irq,
                 mon_e.cnt, mon_e.lp, mon_e.ov, mon_e.un, mon_e.cause, mon_e.irq);
      end
    end
  end

  // driver: one pin change per call; result due three edges later (R12)
  task automatic drv(input bit a, input bit b, input bit z, input bit h, input bit en,
                     input bit [2:0] clr, input string tag);
    exp_t e;
    bit ev_lp, ev_ov, ev_un, ev_hp, fire;
    ev_lp = 0; ev_ov = 0; ev_un = 0; ev_hp = 0;
    a_in = a; b_in = b; z_in = z; hold_in = h; run_en = en;
    if (!a && !b && z) begin
      m_cnt = 0;
    end else if ((a != m_a) && !b && en && !h) begin
      if (a) begin
        if (m_cnt == VMAX) begin m_cnt = VMIN; ev_ov = 1; end
        else m_cnt = m_cnt + 1;
        ev_hp = (m_cnt == $signed(preset_hi));
      end else begin
        if (m_cnt == VMIN) begin m_cnt = VMAX; ev_un = 1; end
        else m_cnt = m_cnt - 1;
        ev_lp = (m_cnt == $signed(preset_lo));
      end
    end
    m_a  = a;
    m_lp = ev_lp | (m_lp & !clr[0]);
    m_ov = ev_ov | (m_ov & !clr[1]);
    m_un = ev_un | (m_un & !clr[2]);
    fire = irq_en && (ev_lp || ev_ov || ev_un || ev_hp);
    if (fire) begin
      if      (ev_ov) m_cause = 4'b0100;
      else if (ev_un) m_cause = 4'b1000;
      else if (ev_lp) m_cause = 4'b0010;
      else            m_cause = 4'b0001;
    end
    e.due = cyc + 3; e.cnt = m_cnt; e.lp = m_lp; e.ov = m_ov; e.un = m_un;
    e.cause = m_cause; e.irq = fire; e.tag = tag;
    sb.push_back(e);
    e.due = cyc + 4; e.irq = 0; e.tag = {tag, " (irq one-cycle, R10)"};
    sb.push_back(e);
    @(negedge clk); @(negedge clk);
    {clr_un, clr_ov, clr_lp} = clr;
    @(negedge clk);
    {clr_un, clr_ov, clr_lp} = 3'b000;
    @(negedge clk);
  endtask

  // count up one step: A rises with B low, then A returns low behind B
  task automatic inc1(input string tag);
    drv(1, 0, 0, 0, 1, 3'b000, tag);
    drv(1, 1, 0, 0, 1, 3'b000, "R3 b high");
    drv(0, 1, 0, 0, 1, 3'b000, "R3 fall blocked");
    drv(0, 0, 0, 0, 1, 3'b000, "R3 b low");
  endtask

  // count down one step: A raised behind B, then falls with B low
  task automatic dec1(input string tag, input bit [2:0] clr);
    drv(0, 1, 0, 0, 1, 3'b000, "R3 b high");
    drv(1, 1, 0, 0, 1, 3'b000, "R3 rise blocked");
    drv(1, 0, 0, 0, 1, 3'b000, "R3 b low");
    drv(0, 0, 0, 0, 1, clr, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (count != '0 || flag_lp || flag_ov || flag_un || cause != 4'b0 || irq) begin
      n_fail++;
      $display("FAIL R13: got cnt=%0d lp=%0b ov=%0b un=%0b cause=%b irq=%0b, expected all zero",
               $signed(count), flag_lp, flag_ov, flag_un, cause, irq);
    end
    preset_lo = W'(3);
    preset_hi = W'(5);
    irq_en    = 1'b1;

    inc1("R1 up to 1");
    dec1("R2 down to 0", 3'b000);
    for (int i = 0; i < 3; i++) inc1("R8 passing lo preset upward");

    // R4: disabled rung, then hold
    drv(1, 0, 0, 0, 0, 3'b000, "R4 run_en low rise");
    drv(0, 0, 0, 0, 0, 3'b000, "R4 run_en low fall");
    drv(1, 0, 0, 1, 1, 3'b000, "R4 hold rise");
    drv(0, 0, 0, 1, 1, 3'b000, "R4 hold fall");

    // R5: zeroing despite hold and disable, then priority over an edge
    drv(0, 0, 1, 1, 0, 3'b000, "R5 zero under hold");
    drv(0, 0, 0, 0, 1, 3'b000, "R5 release");
    inc1("R1 up"); inc1("R1 up");
    drv(1, 0, 0, 0, 1, 3'b000, "R1 up to 3");
    drv(0, 0, 1, 0, 1, 3'b000, "R5 zero beats fall");
    drv(0, 0, 0, 0, 1, 3'b000, "R5 release");

    for (int i = 0; i < 5; i++) inc1("R9 climb to hi preset");
    for (int i = 0; i < VMAX - 5; i++) inc1("R6 climb to top");
    inc1("R6 overflow wrap");
    dec1("R7 underflow wrap", 3'b000);
    for (int i = 0; i < VMAX - 3; i++) dec1("R8 descend to lo preset", 3'b000);

    drv(0, 0, 0, 0, 1, 3'b001, "R11 clear lp only");
    dec1("R8 below preset", 3'b000);
    inc1("R8 landing on preset upward");
    inc1("R8 up to 4");
    dec1("R11 set beats clear", 3'b001);
    inc1("R8 up to 4");

    irq_en = 1'b0;
    inc1("R10 hi preset with irq_en low");
    irq_en = 1'b1;
    dec1("R8 down to 4", 3'b000);
    inc1("R9 hi preset cause");

    drv(0, 0, 0, 0, 1, 3'b010, "R11 clear ov only");
    drv(0, 0, 0, 0, 1, 3'b100, "R11 clear un only");
    drv(0, 0, 0, 0, 1, 3'b001, "R11 clear lp");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R12: %0d expected items never compared, expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule